// File: doc/BRIEF.md
# Ring Trip Detector

This block decides when a line that is being rung has been answered, which happens when the far-end equipment goes off-hook while ringing voltage is on the line. Signed loop-current samples arrive with a valid strobe. A line-state input says whether the line is ringing, and only in that state does the block do anything with the samples.

Each accepted sample is rectified, and its sign is kept so that a separate threshold can be used for each current polarity. The magnitude then goes through a single-pole low-pass filter, which removes the alternating ringing component. The filtered level is compared with the threshold for the current polarity, and the result of that comparison is debounced symmetrically over a programmable number of samples.

When the debounced state changes to "tripped", a sticky status flag is set. If interrupts are enabled, a sticky interrupt flag is set as well. One acknowledge pulse clears both flags. All settings are plain input ports.

Top module: `ring_trip_detector`

## Requirements
- R1: While `ringing` is 0, samples have no effect. At the next clock edge the filter level, the debounce count and the debounced state all return to zero.
- R2: The input stage takes the magnitude of the two's-complement sample. The most negative code maps to 2^(W-1). The sign of the most recent accepted sample is remembered.
- R3: On each accepted sample (`smp_valid`=1 and `ringing`=1), the filter level y is updated to y + ((m - y) >>> k). Here m is the magnitude and k is `filt_shift` (0 to 7). k=0 makes the level follow the sample directly.
- R4: The raw detect is 1 when the filter level is strictly greater than the selected threshold. The selected threshold is `thr_neg` when the most recent accepted sample was negative and `thr_pos` otherwise. The raw detect is evaluated on the filter level as it stands before the update from the current sample.
- R5: The debounced state changes only after the raw detect has disagreed with it on `dbnc_len` consecutive accepted samples. An accepted sample on which they agree restarts the count, and a `dbnc_len` of 0 behaves as 1.
- R6: A change of the debounced state from 0 to 1 sets `trip_status`. The flag stays set until `trip_ack`, and leaving the ringing state does not clear it. A trip in the same cycle as `trip_ack` leaves the flag set.
- R7: `trip_irq` is set by a trip only when `irq_en` is 1. It is cleared by `trip_ack`, and a trip in the same cycle as the acknowledge wins.
- R8: After reset, `trip_status` and `trip_irq` are 0 and all internal state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Loop-current sample strobe |
| smp_data | input | W | Signed loop-current sample |
| ringing | input | 1 | Line is in the ringing state |
| filt_shift | input | 3 | Filter coefficient k |
| thr_pos | input | W | Threshold for positive current |
| thr_neg | input | W | Threshold for negative current |
| dbnc_len | input | 7 | Debounce interval in samples |
| irq_en | input | 1 | Interrupt enable |
| trip_ack | input | 1 | Clears status and interrupt (write-one pulse) |
| trip_status | output | 1 | Latched ring-trip status |
| trip_irq | output | 1 | Pending ring-trip interrupt |

## Verification
A trip, meaning the debounced state reaching 1, can land in the same clock cycle as an acknowledge pulse. The bench sets this up with k=0 and an interval of 1, so that the second accepted large sample trips the detector. It raises `trip_ack` on that cycle and expects both `trip_status` and `trip_irq` to be set afterwards. A behavioural model predicts the outputs on every clock, and it also covers acknowledges that fall on cycles with no trip.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  localparam int CNT_W = 7;

  // Interval 0 is treated as 1.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] len);
    return (len == '0) ? CNT_W'(1) : len;
  endfunction
endpackage

// File: rtl/rtd_front.sv
module rtd_front #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,
  input  logic signed [W-1:0] sample,
  input  logic [2:0]          shift,
  output logic [W-1:0]        level,
  output logic                neg
);
  function automatic logic [W-1:0] mag(input logic signed [W-1:0] s);
    return s[W-1] ? W'(-s) : W'(s);
  endfunction

  function automatic logic [W-1:0] iir_step(input logic [W-1:0] y,
                                             input logic [W-1:0] x,
                                             input logic [2:0]   k);
    logic signed [W:0] d;
    logic signed [W:0] s;
    d = $signed({1'b0, x}) - $signed({1'b0, y});
    d = d >>> k;
    s = $signed({1'b0, y}) + d;
    return s[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      neg   <= 1'b0;
    end else if (clr) begin
      level <= '0;
      neg   <= 1'b0;
    end else if (take) begin
      level <= iir_step(level, mag(sample), shift);
      neg   <= sample[W-1];
    end
  end
endmodule

// File: rtl/rtd_debounce.sv
module rtd_debounce
  import rtd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             raw,
  input  logic [CNT_W-1:0] len,
  output logic             state,
  output logic [CNT_W-1:0] cnt,
  output logic             rise
);
  logic [CNT_W:0] next_cnt;
  logic           differ;
  logic           done;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign differ   = tick && !clr && (raw != state);
  assign done     = differ && (next_cnt >= {1'b0, eff_len(len)});
  assign rise     = done && raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
      cnt   <= '0;
    end else if (clr) begin
      state <= 1'b0;
      cnt   <= '0;
    end else if (tick) begin
      if (done) begin
        state <= raw;
        cnt   <= '0;
      end else if (differ) begin
        cnt   <= next_cnt[CNT_W-1:0];
      end else begin
        cnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/rtd_flags.sv
module rtd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic irq_en,
  input  logic ack,
  output logic status,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (trip)     status <= 1'b1;
      else if (ack) status <= 1'b0;
      if (trip && irq_en) pend <= 1'b1;
      else if (ack)       pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_trip_detector.sv
module ring_trip_detector
  import rtd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_data,
  input  logic                ringing,
  input  logic [2:0]          filt_shift,
  input  logic [W-1:0]        thr_pos,
  input  logic [W-1:0]        thr_neg,
  input  logic [CNT_W-1:0]    dbnc_len,
  input  logic                irq_en,
  input  logic                trip_ack,
  output logic                trip_status,
  output logic                trip_irq
);
  logic             idle;
  logic             take;
  logic [W-1:0]     filt_lvl;
  logic             last_neg;
  logic [W-1:0]     thr_sel;
  logic             raw_det;
  logic             db_state;
  logic [CNT_W-1:0] db_cnt;
  logic             trip_evt;

  assign idle    = !ringing;
  assign take    = smp_valid && ringing;
  assign thr_sel = last_neg ? thr_neg : thr_pos;
  assign raw_det = filt_lvl > thr_sel;

  rtd_front #(.W(W)) u_front (
    .clk(clk), .rst_n(rst_n), .clr(idle), .take(take),
    .sample(smp_data), .shift(filt_shift),
    .level(filt_lvl), .neg(last_neg)
  );

  rtd_debounce u_dbnc (
    .clk(clk), .rst_n(rst_n), .clr(idle), .tick(take),
    .raw(raw_det), .len(dbnc_len),
    .state(db_state), .cnt(db_cnt), .rise(trip_evt)
  );

  rtd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .trip(trip_evt), .irq_en(irq_en),
    .ack(trip_ack), .status(trip_status), .pend(trip_irq)
  );
endmodule

// File: rtl/rtd_checker.sv
module rtd_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ringing,
  input logic         smp_valid,
  input logic         irq_en,
  input logic         trip_ack,
  input logic [W-1:0] filt_lvl,
  input logic         raw_det,
  input logic         db_state,
  input logic [6:0]   db_cnt,
  input logic [6:0]   dbnc_len,
  input logic         trip_evt,
  input logic         trip_status,
  input logic         trip_irq
);
  // R1: idle clears the filter and debounce state
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ringing |=> (filt_lvl == '0 && db_state == 1'b0 && db_cnt == '0));

  // R5: an agreeing sample keeps the debounced state
  a_r5_agree_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ringing && smp_valid && raw_det == db_state) |=> $stable(db_state));

  // R5: a disagreeing sample short of the interval keeps the state
  a_r5_short_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ringing && smp_valid && raw_det != db_state && dbnc_len > 7'd1 &&
     ({1'b0, db_cnt} + 8'd1) < {1'b0, dbnc_len}) |=> $stable(db_state));

  // R6: a trip sets the status, even against an acknowledge
  a_r6_trip_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> trip_status);

  // R6: status stays set without an acknowledge
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_status && !trip_ack) |=> trip_status);

  // R7: a rising interrupt needs an enabled trip
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_irq) |-> $past(trip_evt && irq_en));

  // R7: an enabled trip wins over an acknowledge
  a_r7_trip_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_evt && irq_en) |=> trip_irq);
endmodule

bind ring_trip_detector rtd_checker #(.W(W)) u_rtd_checker (
  .clk(clk), .rst_n(rst_n), .ringing(ringing), .smp_valid(smp_valid),
  .irq_en(irq_en), .trip_ack(trip_ack), .filt_lvl(filt_lvl),
  .raw_det(raw_det), .db_state(db_state), .db_cnt(db_cnt),
  .dbnc_len(dbnc_len), .trip_evt(trip_evt),
  .trip_status(trip_status), .trip_irq(trip_irq)
);

// File: tb/ring_trip_detector_bench.sv
module ring_trip_detector_bench;
  localparam int W = 12;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                smp_valid = 1'b0;
  logic signed [W-1:0] smp_data = '0;
  logic                ringing = 1'b0;
  logic [2:0]          filt_shift = 3'd0;
  logic [W-1:0]        thr_pos = '0;
  logic [W-1:0]        thr_neg = '0;
  logic [6:0]          dbnc_len = 7'd1;
  logic                irq_en = 1'b0;
  logic                trip_ack = 1'b0;
  logic                trip_status;
  logic                trip_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string req = "R8";

  // behavioural reference state
  int m_lvl = 0, m_cnt = 0;
  bit m_neg = 0, m_db = 0, m_st = 0, m_irq = 0;

  always #5 clk = ~clk;

  ring_trip_detector #(.W(W)) u_ring_trip_detector (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .ringing(ringing), .filt_shift(filt_shift), .thr_pos(thr_pos),
    .thr_neg(thr_neg), .dbnc_len(dbnc_len), .irq_en(irq_en),
    .trip_ack(trip_ack), .trip_status(trip_status), .trip_irq(trip_irq)
  );

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", r, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int mg, thr, need, d;
    bit raw, trip;
    trip = 0;
    if (!ringing) begin
      m_lvl = 0; m_cnt = 0; m_db = 0; m_neg = 0;
    end else if (smp_valid) begin
      thr = m_neg ? int'(thr_neg) : int'(thr_pos);
      raw = (m_lvl > thr);
      need = (dbnc_len == 0) ? 1 : int'(dbnc_len);
      if (raw == m_db) m_cnt = 0;
      else if (m_cnt + 1 >= need) begin
        m_db = raw; m_cnt = 0; trip = raw;
      end else m_cnt++;
      mg = (int'(smp_data) < 0) ? -int'(smp_data) : int'(smp_data);
      d = (mg - m_lvl) >>> filt_shift;
      m_lvl = m_lvl + d;
      m_neg = (int'(smp_data) < 0);
    end
    if (trip) m_st = 1; else if (trip_ack) m_st = 0;
    if (trip && irq_en) m_irq = 1; else if (trip_ack) m_irq = 0;
  endtask

  // one clock: model follows the edge, outputs compared after it
  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check({req, " status"}, int'(trip_status), int'(m_st));
    check({req, " irq"}, int'(trip_irq), int'(m_irq));
    @(negedge clk);
    cycles++;
  endtask

  task automatic feed(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1; smp_data = W'(v);
      step();
    end
    smp_valid = 1'b0;
  endtask

  task automatic ack_pulse();
    trip_ack = 1'b1; step(); trip_ack = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 reset status", int'(trip_status), 0);
    check("R8 reset irq", int'(trip_irq), 0);
    rst_n = 1'b1;
    thr_pos = 12'd400; thr_neg = 12'd900; dbnc_len = 7'd3; irq_en = 1'b1;

    // R1: large samples while not ringing do nothing
    req = "R1";
    feed(1500, 10);
    check("R1 no trip idle", int'(trip_status), 0);

    // R3/R4: AC around zero through a slow filter stays below threshold
    req = "R3";
    ringing = 1'b1; filt_shift = 3'd3;
    for (int i = 0; i < 20; i++) feed((i % 2) ? 300 : -300, 1);
    check("R3 ac no trip", int'(trip_status), 0);

    // R3/R5: sustained offset trips through the slow filter
    req = "R5";
    feed(800, 25);
    check("R5 dc trip", int'(trip_status), 1);
    check("R7 irq set", int'(trip_irq), 1);

    // R6: status survives leaving ringing, then ack clears
    req = "R6";
    ringing = 1'b0; step(); step();
    check("R6 sticky after idle", int'(trip_status), 1);
    ack_pulse();
    check("R6 ack clears", int'(trip_status), 0);
    check("R7 ack clears irq", int'(trip_irq), 0);

    // R5: short excursion with k=0 and interval 4 leaves state
    req = "R5";
    ringing = 1'b1; filt_shift = 3'd0; dbnc_len = 7'd4;
    feed(1000, 3); feed(0, 3);
    check("R5 short excursion", int'(trip_status), 0);
    feed(1000, 5);
    check("R5 full interval", int'(trip_status), 1);
    ack_pulse();

    // R2/R4: negative current uses the negative threshold
    req = "R2";
    ringing = 1'b0; step(); ringing = 1'b1; dbnc_len = 7'd1;
    feed(-700, 4);
    check("R2 neg below thr_neg", int'(trip_status), 0);
    feed(-2048, 3);
    check("R2 most negative trips", int'(trip_status), 1);
    ack_pulse();

    // R7: disabled interrupt, status still set
    req = "R7";
    irq_en = 1'b0; ringing = 1'b0; step(); ringing = 1'b1;
    feed(1000, 3);
    check("R7 masked irq", int'(trip_irq), 0);
    check("R6 status masked", int'(trip_status), 1);
    ack_pulse();

    // R6/R7: trip in the same cycle as ack, interval 0 acts as 1
    req = "R6";
    irq_en = 1'b1; dbnc_len = 7'd0; ringing = 1'b0; step(); ringing = 1'b1;
    feed(1000, 1);
    smp_valid = 1'b1; smp_data = W'(1000); trip_ack = 1'b1;
    step();
    smp_valid = 1'b0; trip_ack = 1'b0;
    check("R6 trip beats ack", int'(trip_status), 1);
    check("R7 trip beats ack", int'(trip_irq), 1);
    ack_pulse();

    // R1: state cleared by idle, so one sample cannot trip again
    req = "R1";
    ringing = 1'b0; step(); ringing = 1'b1;
    feed(1000, 1);
    check("R1 restart from zero", int'(trip_status), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule